// File: doc/BRIEF.md
# Line and Field Timing Counter

This block sets the line and frame timing for a progressive-scan image sensor. A horizontal counter steps through the pixel clocks of each line. A vertical counter steps through the lines of a frame. Each counter can be pulled back to zero by an external reference input. These are a horizontal reference and a vertical reference. Each passes through a two-flop synchronizer, and only its rising edge acts.

The block derives three timing outputs from the two counters:

- a line index that alternates on every line, where high marks a red line and low marks a blue line;
- a composite blanking output, which covers a band of lines at the top of the frame and a band of clocks at the start of every line;
- an active-low sweep pulse for the electronic shutter.

The sweep pulse fires near the start of each line that lies before a programmed shutter line. It rests high otherwise. The shutter line is a 10-bit code that takes effect at the next frame start. A code of zero leaves the sweep output high for the whole frame.

The default geometry is 780 pixel clocks per line, 525 lines per frame, and a vertical blanking band of 33 lines. Every size is a parameter.

Top module: `lft_timing_top`

## Requirements
- R1: The horizontal count runs 0 to LINE_CLKS-1 and then returns to 0, and at that return the vertical count advances by one.
- R2: With no vertical reference, the vertical count returns to 0 after line FRAME_LINES-1 ends.
- R3: A rising edge on href_i is acted on at the third rising clock edge after href_i is first sampled high. It sets the horizontal count to 0 and advances the vertical count by one. A level held high acts only once.
- R4: A rising edge on vref_i, acted on at the same latency, sets the vertical count to 0 and drives color_idx_o high. The horizontal count keeps running.
- R5: color_idx_o inverts at every line advance, where high means a red line and low means a blue line.
- R6: cblank_o is high exactly when the vertical count is below VBLANK_LINES or the horizontal count is below HBLANK_CLKS.
- R7: sweep_n_o is low exactly when the horizontal count is below SWEEP_CLKS and the vertical count is below the active shutter code, and it is high otherwise.
- R8: An active shutter code of 0 keeps sweep_n_o high on every line.
- R9: shutter_code_i is taken into the active code only at a frame start, which is either a vertical reference edge or the wrap from the last line. A change in mid-frame has no effect before the next frame start.
- R10: Reset gives horizontal count 0, vertical count 0, color_idx_o high, cblank_o high, sweep_n_o high and an active code of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| href_i | input | 1 | Horizontal reference, asynchronous |
| vref_i | input | 1 | Vertical reference, asynchronous |
| shutter_code_i | input | CODE_W | Shutter line code, 0 disables the sweep |
| h_count_o | output | HW | Pixel position within the line |
| v_count_o | output | VW | Line position within the frame |
| color_idx_o | output | 1 | Line color index, 1 red, 0 blue |
| cblank_o | output | 1 | Composite blanking |
| sweep_n_o | output | 1 | Shutter sweep pulse, active low |

## Verification
A wrong horizontal count shows up within one line. Line advances arrive at the wrong cycle, so the vertical count and the color index move early or late, and the blanking edge and the sweep edge drift away from their expected horizontal positions.

A corrupted vertical count or color parity shows in the next line. The index is then out of step with the line number, or cblank_o closes its vertical band at the wrong line. A stale or early-loaded shutter code becomes visible at the first line whose sweep pulse should or should not appear. The bench probes each of these at exact counter positions, so any error is caught within one frame.

// File: rtl/lft_pkg.sv
package lft_pkg;

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    typedef struct packed {
        logic cblank;
        logic sweep_n;
    } outs_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lft_ref_sync.sv
module lft_ref_sync
    import lft_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic rise_o
);
    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = ref_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.s2 & ~st_q.prev;
endmodule

// File: rtl/lft_line_ctr.sv
module lft_line_ctr #(
    parameter int LINE_CLKS = 780,
    localparam int HW = $clog2(LINE_CLKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          href_rise_i,
    output logic [HW-1:0] h_o,
    output logic [HW-1:0] h_nx_o,
    output logic          line_end_o
);
    localparam logic [HW-1:0] H_LAST = HW'(LINE_CLKS - 1);

    logic [HW-1:0] h_d, h_q;
    logic          at_last;

    always_comb begin
        at_last = (h_q == H_LAST);
        if (href_rise_i || at_last) h_d = '0;
        else                        h_d = h_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign h_o        = h_q;
    assign h_nx_o     = h_d;
    assign line_end_o = href_rise_i | at_last;
endmodule

// File: rtl/lft_frame_ctr.sv
module lft_frame_ctr #(
    parameter int FRAME_LINES = 525,
    parameter int CODE_W      = 10,
    localparam int VW = $clog2(FRAME_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end_i,
    input  logic              vref_rise_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [VW-1:0]     v_o,
    output logic [VW-1:0]     v_nx_o,
    output logic              color_o,
    output logic [CODE_W-1:0] code_nx_o,
    output logic [CODE_W-1:0] code_act_o
);
    localparam logic [VW-1:0] V_LAST = VW'(FRAME_LINES - 1);

    typedef struct packed {
        logic [VW-1:0]     v;
        logic              color;
        logic [CODE_W-1:0] code;
    } fstate_t;

    fstate_t fs_d, fs_q;
    logic    frame_start;

    always_comb begin
        fs_d        = fs_q;
        frame_start = vref_rise_i | (line_end_i & (fs_q.v == V_LAST));
        if (vref_rise_i) begin
            fs_d.v     = '0;
            fs_d.color = 1'b1;
        end else if (line_end_i) begin
            fs_d.v     = (fs_q.v == V_LAST) ? '0 : fs_q.v + 1'b1;
            fs_d.color = ~fs_q.color;
        end
        if (frame_start) fs_d.code = code_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q.v     <= '0;
            fs_q.color <= 1'b1;
            fs_q.code  <= '0;
        end else begin
            fs_q <= fs_d;
        end
    end

    assign v_o        = fs_q.v;
    assign v_nx_o     = fs_d.v;
    assign color_o    = fs_q.color;
    assign code_nx_o  = fs_d.code;
    assign code_act_o = fs_q.code;
endmodule

// File: rtl/lft_timing_top.sv
module lft_timing_top
    import lft_pkg::*;
#(
    parameter int LINE_CLKS    = 780,
    parameter int FRAME_LINES  = 525,
    parameter int VBLANK_LINES = 33,
    parameter int HBLANK_CLKS  = 128,
    parameter int SWEEP_CLKS   = 16,
    parameter int CODE_W       = 10,
    localparam int HW = $clog2(LINE_CLKS),
    localparam int VW = $clog2(FRAME_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              href_i,
    input  logic              vref_i,
    input  logic [CODE_W-1:0] shutter_code_i,
    output logic [HW-1:0]     h_count_o,
    output logic [VW-1:0]     v_count_o,
    output logic              color_idx_o,
    output logic              cblank_o,
    output logic              sweep_n_o
);
    localparam int CW = max_int(VW, CODE_W) + 1;
    localparam int HC = HW + 1;

    logic              href_rise, vref_rise, line_end;
    logic [HW-1:0]     h_nx;
    logic [VW-1:0]     v_nx;
    logic [CODE_W-1:0] code_nx, code_act;

    lft_ref_sync u_hsync (.clk(clk), .rst_n(rst_n), .ref_i(href_i), .rise_o(href_rise));
    lft_ref_sync u_vsync (.clk(clk), .rst_n(rst_n), .ref_i(vref_i), .rise_o(vref_rise));

    lft_line_ctr #(.LINE_CLKS(LINE_CLKS)) u_line (
        .clk(clk), .rst_n(rst_n), .href_rise_i(href_rise),
        .h_o(h_count_o), .h_nx_o(h_nx), .line_end_o(line_end)
    );

    lft_frame_ctr #(.FRAME_LINES(FRAME_LINES), .CODE_W(CODE_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .line_end_i(line_end), .vref_rise_i(vref_rise),
        .code_i(shutter_code_i), .v_o(v_count_o), .v_nx_o(v_nx),
        .color_o(color_idx_o), .code_nx_o(code_nx), .code_act_o(code_act)
    );

    outs_t         out_d, out_q;
    logic [CW-1:0] v_ext, code_ext;
    logic [HC-1:0] h_ext;

    always_comb begin
        v_ext         = CW'(v_nx);
        code_ext      = CW'(code_nx);
        h_ext         = HC'(h_nx);
        out_d         = out_q;
        out_d.cblank  = (v_ext < CW'(VBLANK_LINES)) || (h_ext < HC'(HBLANK_CLKS));
        out_d.sweep_n = !((h_ext < HC'(SWEEP_CLKS)) && (v_ext < code_ext));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.cblank  <= 1'b1;
            out_q.sweep_n <= 1'b1;
        end else begin
            out_q <= out_d;
        end
    end

    assign cblank_o  = out_q.cblank;
    assign sweep_n_o = out_q.sweep_n;
endmodule

// File: rtl/lft_timing_chk.sv
module lft_timing_chk #(
    parameter int LINE_CLKS    = 780,
    parameter int FRAME_LINES  = 525,
    parameter int VBLANK_LINES = 33,
    parameter int HBLANK_CLKS  = 128,
    parameter int CODE_W       = 10,
    localparam int HW = $clog2(LINE_CLKS),
    localparam int VW = $clog2(FRAME_LINES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [HW-1:0]     h,
    input logic [VW-1:0]     v,
    input logic              color,
    input logic              cblank,
    input logic              sweep_n,
    input logic              href_rise,
    input logic              vref_rise,
    input logic [CODE_W-1:0] code_act
);
    localparam logic [HW-1:0] H_LAST = HW'(LINE_CLKS - 1);
    localparam logic [VW-1:0] V_LAST = VW'(FRAME_LINES - 1);

    // R1: the count steps by one inside a line and returns to zero after the last clock
    p_hstep_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!href_rise && h != H_LAST) |=> (h == HW'($past(h) + 1'b1)));
    p_hwrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (h == H_LAST) |=> (h == '0));

    // R2: the line after the last one is line zero
    p_vwrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!vref_rise && h == H_LAST && v == V_LAST) |=> (v == '0));

    // R3: a horizontal reference edge restarts the line
    p_href_r3: assert property (@(posedge clk) disable iff (!rst_n)
        href_rise |=> (h == '0));

    // R4: a vertical reference edge restarts the frame on a red line
    p_vref_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vref_rise |=> (v == '0 && color));

    // R5: the color index flips at each line advance
    p_color_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!vref_rise && (href_rise || h == H_LAST)) |=> (color != $past(color)));

    // R5: the color index stays put within a line
    p_color_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!vref_rise && !href_rise && h != H_LAST) |=> $stable(color));

    // R6: blanking covers the vertical band
    p_cblank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(v) < VBLANK_LINES) |-> cblank);

    // R8: a zero code never sweeps
    p_sweep_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (code_act == '0) |-> sweep_n);
endmodule

bind lft_timing_top lft_timing_chk #(
    .LINE_CLKS(LINE_CLKS), .FRAME_LINES(FRAME_LINES), .VBLANK_LINES(VBLANK_LINES),
    .HBLANK_CLKS(HBLANK_CLKS), .CODE_W(CODE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .h(h_count_o), .v(v_count_o), .color(color_idx_o),
    .cblank(cblank_o), .sweep_n(sweep_n_o), .href_rise(href_rise),
    .vref_rise(vref_rise), .code_act(code_act)
);

// File: tb/sim_lft_timing_top.sv
module sim_lft_timing_top;
    localparam int LC = 40;
    localparam int FL = 50;
    localparam int VB = 5;
    localparam int HB = 8;
    localparam int SW = 3;
    localparam int CODE_W = 10;
    localparam int HW = $clog2(LC);
    localparam int VW = $clog2(FL);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              href = 1'b0;
    logic              vref = 1'b0;
    logic [CODE_W-1:0] code = '0;
    logic [HW-1:0]     h;
    logic [VW-1:0]     v;
    logic              color, cblank, sweep_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    lft_timing_top #(
        .LINE_CLKS(LC), .FRAME_LINES(FL), .VBLANK_LINES(VB),
        .HBLANK_CLKS(HB), .SWEEP_CLKS(SW), .CODE_W(CODE_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .href_i(href), .vref_i(vref),
        .shutter_code_i(code), .h_count_o(h), .v_count_o(v),
        .color_idx_o(color), .cblank_o(cblank), .sweep_n_o(sweep_n)
    );

    // table entries: {line, clock} in time order within one frame started by an aligned reference
    localparam logic [15:0] VEC [13] = '{
        {8'd0, 8'd0}, {8'd0, 8'd2}, {8'd0, 8'd3}, {8'd0, 8'd8},
        {8'd3, 8'd1}, {8'd4, 8'd2}, {8'd4, 8'd3}, {8'd4, 8'd39},
        {8'd5, 8'd0}, {8'd5, 8'd7}, {8'd5, 8'd8}, {8'd6, 8'd2},
        {8'd9, 8'd20}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at line %0d clock %0d", req, act, exp, v, h);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_pos(input int vv, input int hh);
        int guard = 0;
        while (!(int'(v) == vv && int'(h) == hh) && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 5000) begin
            checks++;
            errors++;
            $display("FAIL wait: position line %0d clock %0d never reached", vv, hh);
        end
    endtask

    function automatic int exp_blank(input int vv, input int hh);
        return (vv < VB || hh < HB) ? 1 : 0;
    endfunction

    function automatic int exp_sweep_n(input int vv, input int hh, input int c);
        return (hh < SW && vv < c) ? 0 : 1;
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: run did not finish");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int v0;
        int h0;
        // R10: reset state
        step(3);
        chk("R10 h", int'(h), 0);
        chk("R10 v", int'(v), 0);
        chk("R10 color", int'(color), 1);
        chk("R10 cblank", int'(cblank), 1);
        chk("R10 sweep", int'(sweep_n), 1);
        rst_n = 1'b1;
        step(2);
        chk("R1 h counting", int'(h), 2);

        // align both references, code 5 loaded at the frame start
        code = 10'd5;
        step(5);
        href = 1'b1; vref = 1'b1;
        step(1);
        href = 1'b0; vref = 1'b0;
        step(2);
        chk("R3 R4 aligned h", int'(h), 0);
        chk("R4 aligned v", int'(v), 0);

        // table walk: R1, R5, R6, R7
        foreach (VEC[i]) begin
            int vv = int'(VEC[i][15:8]);
            int hh = int'(VEC[i][7:0]);
            wait_pos(vv, hh);
            chk("R6 cblank", int'(cblank), exp_blank(vv, hh));
            chk("R7 sweep", int'(sweep_n), exp_sweep_n(vv, hh, 5));
            chk("R5 color", int'(color), (vv % 2 == 0) ? 1 : 0);
        end

        // R3: href held high mid-line acts once
        v0 = int'(v); h0 = int'(h);
        href = 1'b1;
        step(2);
        chk("R3 not yet", int'(h), h0 + 2);
        step(1);
        chk("R3 h restart", int'(h), 0);
        chk("R3 v advance", int'(v), v0 + 1);
        chk("R5 color after href", int'(color), ((v0 + 1) % 2 == 0) ? 1 : 0);
        step(10);
        chk("R3 held once h", int'(h), 10);
        chk("R3 held once v", int'(v), v0 + 1);
        href = 1'b0;

        // R9: mid-frame code change ignored until the frame start
        code = 10'd20;
        wait_pos(12, 1);
        chk("R9 ignored mid-frame", int'(sweep_n), 1);
        wait_pos(FL - 1, LC - 1);
        chk("R6 late line open", int'(cblank), 0);
        step(1);
        chk("R2 wrap v", int'(v), 0);
        chk("R2 wrap h", int'(h), 0);
        wait_pos(15, 0);
        chk("R9 new code line 15", int'(sweep_n), 0);
        chk("R5 color line 15", int'(color), 0);
        wait_pos(19, 2);
        chk("R7 last swept line", int'(sweep_n), 0);
        wait_pos(20, 0);
        chk("R7 shutter line stops", int'(sweep_n), 1);

        // R4: vref mid-line with code 0, R8 afterwards
        wait_pos(22, 5);
        code = '0;
        vref = 1'b1;
        step(1);
        vref = 1'b0;
        step(2);
        chk("R4 v reset", int'(v), 0);
        chk("R4 h keeps running", int'(h), 8);
        chk("R4 color red", int'(color), 1);
        wait_pos(1, 0);
        chk("R8 line 1", int'(sweep_n), 1);
        wait_pos(2, 2);
        chk("R8 line 2", int'(sweep_n), 1);
        chk("R6 top band", int'(cblank), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule